// File: doc/BRIEF.md
# I/O Window Alias Decoder

This block translates accesses that arrive through five small I/O-space windows into offsets within a single 512-byte internal register space. A requester supplies a window index, an offset inside that window, an access size and a read or write strobe. The decoder computes the internal offset. It then decides whether the access goes on to the register space or is suppressed. When a suppressed access is a read, the decoder supplies an all-ones value of the access width in place of register data.

Two of the mapped ranges are disk-taskfile register files, and each of them has a control byte. Wide accesses to these ranges are limited. Every taskfile byte accepts byte accesses. Only the data port at the start of each taskfile range also accepts 16-bit and 32-bit accesses. The control bytes accept byte accesses only. An offset that lies past the end of its window, or a window index with no window behind it, is reported as a decode miss and causes no internal access. By default the decision is held in one output register stage with a valid flag. A parameter can remove that stage so the decoder is purely combinational.

Top module: `io_window_decoder`

## Requirements
- R1: Window 0 maps 8 bytes at base 0x80, window 1 maps 4 bytes at 0x88, window 2 maps 8 bytes at 0xC0, window 3 maps 4 bytes at 0xC8 and window 4 maps 16 bytes at 0x00. For a hit, int_off_o equals the window base plus off_i.
- R2: An access with off_i at or beyond the window length, or with win_i of 5 or more, gives miss_o=1, fwd_o=0, sub_o=0, int_off_o=0 and fill_o=0.
- R3: A byte access (size_i=0) that hits any window is forwarded: fwd_o=1, sub_o=0.
- R4: A 16-bit (size_i=1) or 32-bit (size_i=2; size_i=3 is treated as 32-bit) access to the data port at internal offset 0x80 or 0xC0 is forwarded.
- R5: A wide read to internal offsets 0x81 to 0x87 or 0xC1 to 0xC7 is not forwarded. It gives sub_o=1, with fill_o=0x0000FFFF for 16-bit and 0xFFFFFFFF for 32-bit.
- R6: A wide write to internal offsets 0x81 to 0x87 or 0xC1 to 0xC7 is dropped: fwd_o=0, sub_o=0, miss_o=0.
- R7: At the control bytes 0x8A and 0xCA, a wide read gives sub_o=1 with the all-ones fill of its width, and a wide write gives fwd_o=0 and sub_o=0.
- R8: Every other hit offset (0x00 to 0x0F, 0x88, 0x89, 0x8B, 0xC8, 0xC9, 0xCB) forwards accesses of any size.
- R9: With neither rd_i nor wr_i high, valid_o, miss_o, fwd_o and sub_o are all 0. When both strobes are high, the access is treated as a write (we_o=1).
- R10: With REG_OUT=1 (the default), the outputs reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R11: While rst_ni is low, and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| win_i | input | 3 | Window select index |
| off_i | input | 4 | Byte offset inside the window |
| size_i | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit, 3 treated as 32-bit |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe (wins over rd_i) |
| valid_o | output | 1 | A decoded access is presented |
| we_o | output | 1 | Decoded access is a write |
| miss_o | output | 1 | Offset or window outside any mapping |
| fwd_o | output | 1 | Forward the access to the register space |
| sub_o | output | 1 | Suppressed read: use fill_o as read data |
| int_off_o | output | 9 | Internal register offset |
| fill_o | output | 32 | All-ones substitute read value for the access width |

## Verification
The bench goes after the edges of each window. It checks the last in-range offset and the first out-of-range offset of every window. A decoder with an off-by-one length compare would forward into a neighbouring window, or would miss a legal byte. It drives every size at the data ports and at the bytes just after them. A decoder that tests the wrong offset bits would either block legal wide data transfers or let wide accesses reach taskfile bytes that accept bytes only. It checks the control bytes and the fill width for both read and write. A fill of the wrong width, or a write that raises the substitute flag, would corrupt host read data or report phantom reads.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  localparam int NUM_WIN = 5;
  localparam int WIN_W   = 3;
  localparam int OFF_W   = 4;
  localparam int ADDR_W  = 9;
  localparam int DATA_W  = 32;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_X = 2'd3} size_e;

  typedef struct packed {
    logic              valid;
    logic              we;
    logic              miss;
    logic              fwd;
    logic              sub;
    logic [ADDR_W-1:0] off;
    logic [DATA_W-1:0] fill;
  } dec_s;

  function automatic logic [ADDR_W-1:0] win_base(int i);
    case (i)
      0: return ADDR_W'(9'h080);
      1: return ADDR_W'(9'h088);
      2: return ADDR_W'(9'h0C0);
      3: return ADDR_W'(9'h0C8);
      default: return '0;
    endcase
  endfunction

  function automatic logic [OFF_W:0] win_len(int i);
    case (i)
      0, 2: return (OFF_W+1)'(8);
      1, 3: return (OFF_W+1)'(4);
      default: return (OFF_W+1)'(16);
    endcase
  endfunction
endpackage

// File: rtl/iowin_map.sv
module iowin_map
  import iowin_pkg::*;
#(
  parameter int N_WIN = NUM_WIN,
  parameter int W_W   = WIN_W,
  parameter int O_W   = OFF_W,
  parameter int A_W   = ADDR_W
) (
  input  logic [W_W-1:0] win_i,
  input  logic [O_W-1:0] off_i,
  output logic           hit_o,
  output logic [A_W-1:0] int_off_o
);
  logic [N_WIN-1:0]          hit_v;
  logic [N_WIN-1:0][A_W-1:0] off_v;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    assign hit_v[g] = (win_i == W_W'(g)) && ({1'b0, off_i} < win_len(g));
    assign off_v[g] = win_base(g) + A_W'(off_i);
  end

  always_comb begin
    int_off_o = '0;
    for (int i = 0; i < N_WIN; i++)
      if (hit_v[i]) int_off_o = int_off_o | off_v[i];
  end

  assign hit_o = |hit_v;
endmodule

// File: rtl/iowin_size_rule.sv
module iowin_size_rule
  import iowin_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int D_W = DATA_W,
  parameter logic [A_W-1:0] TF0 = A_W'(9'h080),
  parameter logic [A_W-1:0] TF1 = A_W'(9'h0C0),
  parameter logic [A_W-1:0] CT0 = A_W'(9'h08A),
  parameter logic [A_W-1:0] CT1 = A_W'(9'h0CA)
) (
  input  logic [A_W-1:0] int_off_i,
  input  size_e          size_i,
  output logic           allow_o,
  output logic [D_W-1:0] fill_o
);
  localparam int GRP = 3;  // taskfile range spans 8 bytes

  logic in_tf, in_ctl, wide;

  assign in_tf  = (int_off_i[A_W-1:GRP] == TF0[A_W-1:GRP]) ||
                  (int_off_i[A_W-1:GRP] == TF1[A_W-1:GRP]);
  assign in_ctl = (int_off_i == CT0) || (int_off_i == CT1);
  assign wide   = (size_i != SZ_B);

  always_comb begin
    if (!wide)      allow_o = 1'b1;
    else if (in_tf) allow_o = (int_off_i[GRP-1:0] == '0);
    else            allow_o = !in_ctl;
  end

  assign fill_o = (size_i == SZ_H) ? D_W'(16'hFFFF) : '1;
endmodule

// File: rtl/iowin_pipe.sv
module iowin_pipe #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    logic [W-1:0] q;
    logic         past_ok;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q       <= '0;
        past_ok <= 1'b0;
      end else begin
        q       <= d_i;
        past_ok <= 1'b1;
      end
    end
    assign q_o = q;

    AST_PIPE_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> (q_o[W-1] == $past(valid_i))) else $error("pipe delay"); // R10
  end else begin : g_comb
    assign q_o = d_i;
  end
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
  import iowin_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIN_W-1:0]  win_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              valid_o,
  output logic              we_o,
  output logic              miss_o,
  output logic              fwd_o,
  output logic              sub_o,
  output logic [ADDR_W-1:0] int_off_o,
  output logic [DATA_W-1:0] fill_o
);
  localparam int DW = $bits(dec_s);

  logic              hit, allow, req;
  logic [ADDR_W-1:0] map_off;
  logic [DATA_W-1:0] rule_fill;
  dec_s              d, q;

  iowin_map u_map (
    .win_i    (win_i),
    .off_i    (off_i),
    .hit_o    (hit),
    .int_off_o(map_off)
  );

  iowin_size_rule u_rule (
    .int_off_i(map_off),
    .size_i   (size_e'(size_i)),
    .allow_o  (allow),
    .fill_o   (rule_fill)
  );

  assign req = rd_i | wr_i;

  always_comb begin
    d       = '0;
    d.valid = req;
    d.we    = wr_i;
    d.miss  = req && !hit;
    d.fwd   = req && hit && allow;
    d.sub   = req && hit && !allow && !wr_i;
    d.off   = (req && hit) ? map_off : '0;
    d.fill  = d.sub ? rule_fill : '0;
  end

  iowin_pipe #(.W(DW), .REG_OUT(REG_OUT)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(d.valid),
    .d_i    (d),
    .q_o    (q)
  );

  assign valid_o   = q.valid;
  assign we_o      = q.we;
  assign miss_o    = q.miss;
  assign fwd_o     = q.fwd;
  assign sub_o     = q.sub;
  assign int_off_o = q.off;
  assign fill_o    = q.fill;

  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (!fwd_o && !sub_o && int_off_o == '0)) else $error("miss"); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!fwd_o && !sub_o && !miss_o)) else $error("idle"); // R9
  AST_SUB_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_o |-> (!we_o && !fwd_o)) else $error("sub on write"); // R6
  AST_FILL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_o |-> (fill_o[15:0] == 16'hFFFF)) else $error("fill"); // R5
  AST_WIDE_DATAPORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && hit && allow && size_i != 2'd0 && map_off[8:7] != 2'b00 &&
     map_off[3] == 1'b0) |-> (map_off[2:0] == 3'd0)) else $error("wide tf"); // R4
endmodule

// File: tb/sim_io_window_decoder.sv
module sim_io_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  win = '0;
  logic [3:0]  off = '0;
  logic [1:0]  size = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic        valid, we, miss, fwd, sub;
  logic [8:0]  ioff;
  logic [31:0] fill;
  int          errors = 0, checks = 0;

  always #4 clk = ~clk;  // 125 MHz

  io_window_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .win_i(win), .off_i(off), .size_i(size),
    .rd_i(rd), .wr_i(wr), .valid_o(valid), .we_o(we), .miss_o(miss),
    .fwd_o(fwd), .sub_o(sub), .int_off_o(ioff), .fill_o(fill)
  );

  typedef logic [45:0] res_t;  // {valid,we,miss,fwd,sub,off[8:0],fill[31:0]}

  function automatic res_t model(logic [2:0] w, logic [3:0] o, logic [1:0] s,
                                 logic r, logic wt);
    int base, len, a;
    logic v, m, f, sb, tf, ct, wide;
    logic [31:0] fl;
    case (w)
      3'd0: begin base = 'h80; len = 8;  end
      3'd1: begin base = 'h88; len = 4;  end
      3'd2: begin base = 'hC0; len = 8;  end
      3'd3: begin base = 'hC8; len = 4;  end
      3'd4: begin base = 'h00; len = 16; end
      default: begin base = 0; len = 0; end
    endcase
    v = r | wt;
    if (!v) return '0;
    if (int'(o) >= len) return {1'b1, wt, 1'b1, 43'd0};
    a    = base + int'(o);
    tf   = (a >= 'h80 && a <= 'h87) || (a >= 'hC0 && a <= 'hC7);
    ct   = (a == 'h8A) || (a == 'hCA);
    wide = (s != 2'd0);
    f    = !wide || (tf ? (a == 'h80 || a == 'hC0) : !ct);
    sb   = !f && !wt;
    fl   = sb ? ((s == 2'd1) ? 32'h0000FFFF : 32'hFFFFFFFF) : 32'd0;
    m    = 1'b0;
    return {v, wt, m, f, sb, 9'(a), fl};
  endfunction

  function automatic string tag(logic [2:0] w, logic [3:0] o, logic [1:0] s,
                                logic r, logic wt);
    res_t e = model(w, o, s, r, wt);
    int a = int'(e[40:32]);
    if (!(r | wt)) return "R9";
    if (e[43]) return "R2";
    if (s == 2'd0) return "R1 R3";
    if (a == 'h80 || a == 'hC0) return "R4";
    if ((a > 'h80 && a <= 'h87) || (a > 'hC0 && a <= 'hC7)) return wt ? "R6" : "R5";
    if (a == 'h8A || a == 'hCA) return "R7";
    return "R8";
  endfunction

  function automatic res_t got();
    return {valid, we, miss, fwd, sub, ioff, fill};
  endfunction

  task automatic chk(string req, res_t act, res_t exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic acc(logic [2:0] w, logic [3:0] o, logic [1:0] s, logic r, logic wt);
    win = w; off = o; size = s; rd = r; wr = wt;
    @(negedge clk);
    chk(tag(w, o, s, r, wt), got(), model(w, o, s, r, wt));
  endtask

  initial begin : watchdog
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    res_t prev;
    void'($urandom(32'd1234));
    #3;
    chk("R11", got(), '0);
    repeat (3) @(negedge clk);
    rd = 1'b1; win = 3'd4;
    #8;
    chk("R11", got(), '0);
    rd = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", got(), '0);

    // window ends and first offset past each window
    for (int w = 0; w < 5; w++) begin
      acc(3'(w), 4'd0, 2'd0, 1'b1, 1'b0);
      acc(3'(w), (w == 4) ? 4'd15 : ((w % 2) ? 4'd3 : 4'd7), 2'd0, 1'b0, 1'b1);
      if (w != 4) acc(3'(w), (w % 2) ? 4'd4 : 4'd8, 2'd0, 1'b1, 1'b0);
    end
    acc(3'd5, 4'd0, 2'd0, 1'b1, 1'b0);  // R2 no window
    acc(3'd7, 4'd2, 2'd2, 1'b0, 1'b1);  // R2
    // all sizes on taskfile and control bytes
    for (int s = 0; s < 4; s++) begin
      acc(3'd0, 4'd0, 2'(s), 1'b1, 1'b0);  // R4 data port
      acc(3'd2, 4'd0, 2'(s), 1'b0, 1'b1);  // R4
      acc(3'd0, 4'd1, 2'(s), 1'b1, 1'b0);  // R5
      acc(3'd2, 4'd7, 2'(s), 1'b0, 1'b1);  // R6
      acc(3'd1, 4'd2, 2'(s), 1'b1, 1'b0);  // R7
      acc(3'd3, 4'd2, 2'(s), 1'b0, 1'b1);  // R7
      acc(3'd1, 4'd3, 2'(s), 1'b1, 1'b0);  // R8
      acc(3'd4, 4'd9, 2'(s), 1'b1, 1'b0);  // R8
    end
    acc(3'd0, 4'd3, 2'd1, 1'b1, 1'b1);  // R9 both strobes -> write
    acc(3'd0, 4'd3, 2'd1, 1'b0, 1'b0);  // R9 idle

    // R10: outputs hold until the next edge
    acc(3'd4, 4'd5, 2'd2, 1'b1, 1'b0);
    prev = got();
    win = 3'd2; off = 4'd3; size = 2'd1; rd = 1'b1; wr = 1'b0;
    #1;
    chk("R10", got(), prev);
    @(negedge clk);
    chk("R10", got(), model(3'd2, 4'd3, 2'd1, 1'b1, 1'b0));

    for (int i = 0; i < 400; i++) begin
      logic [2:0] rw = 3'($urandom_range(0, 5));
      logic [3:0] ro = 4'($urandom);
      logic [1:0] rs = 2'($urandom);
      logic [1:0] st = 2'($urandom);
      acc(rw, ro, rs, st[0], st[1]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule